// File: doc/BRIEF.md
# Capture Configuration Stream Decoder

This block sits between a host data channel and a logic-analyser capture engine. The host sends one configuration frame as a sequence of 16-bit words. The decoder waits for an opening sync pattern. It then reads a series of tagged records. Each record is one header word followed by the payload words that the header announces. The decoder loads each payload into the matching configuration register. The frame is closed by a separate closing sync pattern, and the decoder then gives a one-cycle strobe telling the capture engine that the settings are complete.

The registers it drives are:
- the mode word, whose bits are decoded downstream: bit 0 trigger enable, bit 1 external clock, bit 2 falling clock edge, bit 3 run-length encoding, bit 5 half mode, bit 6 quarter mode, bit 12 streaming, bits 13 to 15 test modes;
- a 32-bit clock divider, equal to the 100 MHz base rate divided by the requested rate and rounded up;
- a 32-bit sample count, counted in units of 16 samples;
- a 32-bit trigger position;
- a trigger-global word;
- a channel-enable mask.

The long trigger-stage table is not held in the block. It is passed out, one word per cycle, through a RAM write port. Records whose tag is unknown, or whose length does not match their tag, are stepped over. A framing violation raises an error flag and sends the decoder back to hunting for the opening sync.

Top module: `cfg_stream_decoder`

## Requirements
- R1: After reset every configuration output is zero, and `cfgValid`, `cfgError` and `stageWrEn` are low.
- R2: A frame opens when two consecutive accepted words are both 0xF5A5, the low half of the 32-bit sync 0xF5A5F5A5 arriving first. Completing this sync clears `cfgError`.
- R3: While hunting, any accepted word other than 0xF5A5 sets `cfgError`. A first 0xF5A5 followed by any other word also sets `cfgError`. Neither case changes any configuration output.
- R4: A header word carries a record tag in bits 15:8 and a payload length, counted in 16-bit words, in bits 7:0. These tag/length pairs each load one full word:
  - tag 0 with length 1 loads `modeWord`;
  - tag 7 with length 1 loads `trigGlobal`;
  - tag 8 with length 1 loads `chanEnable`.
- R5: These tag/length pairs each carry a 32-bit field as two payload words, the first word giving bits 15:0 and the second giving bits 31:16:
  - tag 1 with length 2 loads `clkDivider`;
  - tag 3 with length 2 loads `sampleCount`;
  - tag 5 with length 2 loads `trigPos`.
- R6: Tag 64 with length 160 is the trigger table. Payload word k produces a one-cycle `stageWrEn` pulse with `stageWrAddr` = k and `stageWrData` = that word, in the cycle after the word is accepted.
- R7: A record with an unknown tag, or a known tag with the wrong length, has its payload words consumed and discarded. No register changes and no `stageWrEn` pulse occurs.
- R8: The word 0xFA5A in header position, followed by a second 0xFA5A (the closing sync 0xFA5AFA5A), ends the frame. `cfgValid` is then high for exactly one cycle, the cycle after the second word is accepted, and the decoder returns to hunting.
- R9: If the word after a header-position 0xFA5A is not 0xFA5A, `cfgError` is set, `cfgValid` stays low, and the decoder returns to hunting. Headers sent afterwards load nothing.
- R10: Cycles with `wordValid` low advance no state. A frame sent with idle gaps between words gives the same results as one sent without gaps.
- R11: A header with length 0 has no payload, and the next accepted word is read as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Input word present this cycle |
| wordData | input | 16 | Input stream word |
| modeWord | output | 16 | Mode register |
| clkDivider | output | 32 | Sample clock divider |
| sampleCount | output | 32 | Sample count in units of 16 samples |
| trigPos | output | 32 | Trigger position |
| trigGlobal | output | 16 | Trigger-global word |
| chanEnable | output | 16 | Channel-enable mask |
| stageWrEn | output | 1 | Trigger-table write strobe |
| stageWrAddr | output | 8 | Trigger-table word index |
| stageWrData | output | 16 | Trigger-table word |
| cfgValid | output | 1 | One-cycle frame-complete strobe |
| cfgError | output | 1 | Framing error flag |

## Verification
The assertions assume `wordValid` and `wordData` are free of X after reset, and that nothing outside the stream changes the decoder's registers. Every word only counts in a cycle where `wordValid` is high. The stimulus drives both inputs on the falling edge from known values and releases `wordValid` between words. Some frames are sent with idle gaps, so the stall rule is exercised without ever presenting undefined data.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W = 8;
  localparam logic [WORD_W-1:0] OPEN_WORD = 16'hF5A5;
  localparam logic [WORD_W-1:0] CLOSE_WORD = 16'hFA5A;

  localparam logic [7:0] TAG_MODE = 8'd0;
  localparam logic [7:0] TAG_DIV = 8'd1;
  localparam logic [7:0] TAG_CNT = 8'd3;
  localparam logic [7:0] TAG_TPOS = 8'd5;
  localparam logic [7:0] TAG_TGLB = 8'd7;
  localparam logic [7:0] TAG_CHEN = 8'd8;
  localparam logic [7:0] TAG_TRIG = 8'd64;

  typedef enum logic [2:0] {
    F_SKIP, F_MODE, F_DIV, F_CNT, F_TPOS, F_TGLB, F_CHEN, F_TRIG
  } field_e;

  typedef struct packed {
    logic load;
    field_e field;
    logic [LEN_W-1:0] idx;
  } strobe_t;

  function automatic field_e decodeField(input logic [7:0] tag,
                                         input logic [LEN_W-1:0] len,
                                         input logic [LEN_W-1:0] trigLen);
    field_e f;
    f = F_SKIP;
    case (tag)
      TAG_MODE: if (len == 8'd1) f = F_MODE;
      TAG_DIV:  if (len == 8'd2) f = F_DIV;
      TAG_CNT:  if (len == 8'd2) f = F_CNT;
      TAG_TPOS: if (len == 8'd2) f = F_TPOS;
      TAG_TGLB: if (len == 8'd1) f = F_TGLB;
      TAG_CHEN: if (len == 8'd1) f = F_CHEN;
      TAG_TRIG: if (len == trigLen) f = F_TRIG;
      default:  f = F_SKIP;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/cfgdec_ctrl.sv
module cfgdec_ctrl
  import cfgdec_pkg::*;
#(
  parameter int TRIG_WORDS = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output strobe_t           strobe,
  output logic              cfgValid,
  output logic              cfgError
);
  localparam logic [LEN_W-1:0] TRIG_LEN = LEN_W'(TRIG_WORDS);

  typedef enum logic [2:0] {S_HUNT, S_OPEN_HI, S_HDR, S_PAY, S_CLOSE_HI} state_e;

  state_e state;
  field_e curField;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] idx;

  logic [7:0] hdrTag;
  logic [LEN_W-1:0] hdrLen;
  assign hdrTag = wordData[15:8];
  assign hdrLen = wordData[7:0];

  always_comb begin
    strobe.load = (state == S_PAY) && wordValid && (curField != F_SKIP);
    strobe.field = curField;
    strobe.idx = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_HUNT;
      curField <= F_SKIP;
      remain <= '0;
      idx <= '0;
      cfgValid <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      cfgValid <= 1'b0;
      if (wordValid) begin
        case (state)
          S_HUNT: begin
            if (wordData == OPEN_WORD) state <= S_OPEN_HI;
            else cfgError <= 1'b1;
          end
          S_OPEN_HI: begin
            if (wordData == OPEN_WORD) begin
              state <= S_HDR;
              cfgError <= 1'b0;
            end else begin
              state <= S_HUNT;
              cfgError <= 1'b1;
            end
          end
          S_HDR: begin
            if (wordData == CLOSE_WORD) begin
              state <= S_CLOSE_HI;
            end else if (hdrLen != '0) begin
              curField <= decodeField(hdrTag, hdrLen, TRIG_LEN);
              remain <= hdrLen;
              idx <= '0;
              state <= S_PAY;
            end
          end
          S_PAY: begin
            remain <= remain - 1'b1;
            idx <= idx + 1'b1;
            if (remain == 8'd1) state <= S_HDR;
          end
          S_CLOSE_HI: begin
            state <= S_HUNT;
            if (wordData == CLOSE_WORD) cfgValid <= 1'b1;
            else cfgError <= 1'b1;
          end
          default: state <= S_HUNT;
        endcase
      end
    end
  end

  // R8: the completion strobe lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> !cfgValid);

  // R9: a completed frame never coexists with a raised error
  a_r9_valid_no_error: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> !cfgError);

  // R10: idle input cycles hold the parser still
  a_r10_stall: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> $stable(state) && $stable(remain) && $stable(idx));

  // R11: a payload phase never holds a zero remaining count
  a_r11_no_empty_payload: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PAY) |-> (remain != '0));
endmodule

// File: rtl/cfgdec_regs.sv
module cfgdec_regs
  import cfgdec_pkg::*;
#(
  parameter int TRIG_WORDS = 160,
  localparam int ADDR_W = $clog2(TRIG_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] wordData,
  output logic [15:0]       modeWord,
  output logic [31:0]       clkDivider,
  output logic [31:0]       sampleCount,
  output logic [31:0]       trigPos,
  output logic [15:0]       trigGlobal,
  output logic [15:0]       chanEnable,
  output logic              stageWrEn,
  output logic [ADDR_W-1:0] stageWrAddr,
  output logic [WORD_W-1:0] stageWrData
);
  logic hiHalf;
  assign hiHalf = strobe.idx[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeWord <= '0;
      clkDivider <= '0;
      sampleCount <= '0;
      trigPos <= '0;
      trigGlobal <= '0;
      chanEnable <= '0;
      stageWrEn <= 1'b0;
      stageWrAddr <= '0;
      stageWrData <= '0;
    end else begin
      stageWrEn <= 1'b0;
      if (strobe.load) begin
        case (strobe.field)
          F_MODE: modeWord <= wordData;
          F_TGLB: trigGlobal <= wordData;
          F_CHEN: chanEnable <= wordData;
          F_DIV: begin
            if (hiHalf) clkDivider[31:16] <= wordData;
            else clkDivider[15:0] <= wordData;
          end
          F_CNT: begin
            if (hiHalf) sampleCount[31:16] <= wordData;
            else sampleCount[15:0] <= wordData;
          end
          F_TPOS: begin
            if (hiHalf) trigPos[31:16] <= wordData;
            else trigPos[15:0] <= wordData;
          end
          F_TRIG: begin
            stageWrEn <= 1'b1;
            stageWrAddr <= strobe.idx[ADDR_W-1:0];
            stageWrData <= wordData;
          end
          default: ;
        endcase
      end
    end
  end

  // R6: table writes stay inside the table
  a_r6_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    stageWrEn |-> ({1'b0, stageWrAddr} < (ADDR_W+1)'(TRIG_WORDS)));

  // R7: without a load strobe no configuration register moves
  a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(modeWord) && $stable(clkDivider) && $stable(sampleCount)
      && $stable(trigPos) && $stable(trigGlobal) && $stable(chanEnable) && !stageWrEn);
endmodule

// File: rtl/cfg_stream_decoder.sv
module cfg_stream_decoder
  import cfgdec_pkg::*;
#(
  parameter int TRIG_WORDS = 160,
  localparam int ADDR_W = $clog2(TRIG_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [15:0]       wordData,
  output logic [15:0]       modeWord,
  output logic [31:0]       clkDivider,
  output logic [31:0]       sampleCount,
  output logic [31:0]       trigPos,
  output logic [15:0]       trigGlobal,
  output logic [15:0]       chanEnable,
  output logic              stageWrEn,
  output logic [ADDR_W-1:0] stageWrAddr,
  output logic [15:0]       stageWrData,
  output logic              cfgValid,
  output logic              cfgError
);
  strobe_t strobe;

  cfgdec_ctrl #(.TRIG_WORDS(TRIG_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .strobe(strobe), .cfgValid(cfgValid), .cfgError(cfgError)
  );

  cfgdec_regs #(.TRIG_WORDS(TRIG_WORDS)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordData(wordData),
    .modeWord(modeWord), .clkDivider(clkDivider), .sampleCount(sampleCount),
    .trigPos(trigPos), .trigGlobal(trigGlobal), .chanEnable(chanEnable),
    .stageWrEn(stageWrEn), .stageWrAddr(stageWrAddr), .stageWrData(stageWrData)
  );
endmodule

// File: tb/tb_cfg_stream_decoder.sv
module tb_cfg_stream_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic [15:0] modeWord, trigGlobal, chanEnable, stageWrData;
  logic [31:0] clkDivider, sampleCount, trigPos;
  logic stageWrEn, cfgValid, cfgError;
  logic [7:0] stageWrAddr;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cfg_stream_decoder dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .modeWord(modeWord), .clkDivider(clkDivider), .sampleCount(sampleCount),
    .trigPos(trigPos), .trigGlobal(trigGlobal), .chanEnable(chanEnable),
    .stageWrEn(stageWrEn), .stageWrAddr(stageWrAddr), .stageWrData(stageWrData),
    .cfgValid(cfgValid), .cfgError(cfgError)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one word at a falling edge; returns at the next falling edge
  task automatic sendWord(input logic [15:0] w, input int gap = 0);
    wordValid = 1'b1;
    wordData = w;
    @(negedge clk);
    wordValid = 1'b0;
    wordData = 16'h0;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic openFrame(input int gap = 0);
    sendWord(16'hF5A5, gap);
    sendWord(16'hF5A5, gap);
  endtask

  task automatic closeFrame();
    sendWord(16'hFA5A);
    sendWord(16'hFA5A);
  endtask

  task automatic t_reset();
    check("R1 modeWord", modeWord, 0);
    check("R1 divider", clkDivider, 0);
    check("R1 count", sampleCount, 0);
    check("R1 trigPos", trigPos, 0);
    check("R1 flags", {trigGlobal, chanEnable}, 0);
    check("R1 strobes", {stageWrEn, cfgValid, cfgError}, 0);
  endtask

  task automatic t_fullFrame();
    openFrame();
    check("R2 open no error", cfgError, 0);
    sendWord(16'h0001); sendWord(16'h1003);
    check("R4 mode", modeWord, 32'h1003);
    sendWord(16'h0102); sendWord(16'h5678); sendWord(16'h1234);
    check("R5 divider", clkDivider, 32'h12345678);
    sendWord(16'h0302); sendWord(16'h0400); sendWord(16'h0001);
    check("R5 count", sampleCount, 32'h00010400);
    sendWord(16'h0502); sendWord(16'hBEEF); sendWord(16'hCAFE);
    check("R5 trigPos", trigPos, 32'hCAFEBEEF);
    sendWord(16'h0701); sendWord(16'h0041);
    check("R4 trigGlobal", trigGlobal, 32'h0041);
    sendWord(16'h0801); sendWord(16'h00FF);
    check("R4 chanEnable", chanEnable, 32'h00FF);
    sendWord(16'hFA5A);
    check("R8 no early valid", cfgValid, 0);
    sendWord(16'hFA5A);
    check("R8 valid pulse", cfgValid, 1);
    @(negedge clk);
    check("R8 valid one cycle", cfgValid, 0);
    check("R8 no error", cfgError, 0);
  endtask

  task automatic t_trigTable();
    int errs = 0;
    openFrame();
    sendWord(16'h40A0);
    for (int k = 0; k < 160; k++) begin
      sendWord(16'hA000 ^ 16'(k));
      if (stageWrEn !== 1'b1 || stageWrAddr !== 8'(k) || stageWrData !== (16'hA000 ^ 16'(k))) begin
        errs++;
        $display("FAIL R6 word %0d actual=%b/%0d/%h expected=1/%0d/%h",
                 k, stageWrEn, stageWrAddr, stageWrData, k, 16'hA000 ^ 16'(k));
      end
    end
    total++;
    if (errs != 0) bad++;
    @(negedge clk);
    check("R6 pulse ends", stageWrEn, 0);
    closeFrame();
    check("R6 frame valid", cfgValid, 1);
  endtask

  task automatic t_skip();
    int wr = 0;
    openFrame();
    sendWord(16'h2003);
    for (int k = 0; k < 3; k++) begin sendWord(16'h0001); wr += stageWrEn; end
    sendWord(16'h0002);
    for (int k = 0; k < 2; k++) begin sendWord(16'h7777); wr += stageWrEn; end
    sendWord(16'h4010);
    for (int k = 0; k < 16; k++) begin sendWord(16'h0801); wr += stageWrEn; end
    check("R7 no writes", wr, 0);
    check("R7 mode kept", modeWord, 32'h1003);
    check("R7 chanEnable kept", chanEnable, 32'h00FF);
    sendWord(16'h0000);
    sendWord(16'h0001); sendWord(16'h0055);
    check("R11 zero length then header", modeWord, 32'h0055);
    closeFrame();
    check("R7 frame valid", cfgValid, 1);
  endtask

  task automatic t_idleJunk();
    sendWord(16'h1234);
    check("R3 junk sets error", cfgError, 1);
    check("R3 mode kept", modeWord, 32'h0055);
    sendWord(16'hF5A5);
    sendWord(16'h1111);
    check("R3 bad second sync", cfgError, 1);
    sendWord(16'h0001); sendWord(16'h0099);
    check("R3 no load while hunting", modeWord, 32'h0055);
    openFrame();
    check("R2 sync clears error", cfgError, 0);
    closeFrame();
  endtask

  task automatic t_badClose();
    openFrame();
    sendWord(16'h0001); sendWord(16'h00AA);
    sendWord(16'hFA5A);
    sendWord(16'h0000);
    check("R9 error on bad close", cfgError, 1);
    check("R9 no valid", cfgValid, 0);
    @(negedge clk);
    check("R9 still no valid", cfgValid, 0);
    sendWord(16'h0001); sendWord(16'h0077);
    check("R9 hunting ignores header", modeWord, 32'h00AA);
  endtask

  task automatic t_gaps();
    openFrame(3);
    check("R10 open with gaps", cfgError, 0);
    sendWord(16'h0102, 2); sendWord(16'h0003, 4); sendWord(16'h0000, 1);
    check("R10 divider with gaps", clkDivider, 32'h00000003);
    sendWord(16'hFA5A, 5);
    check("R10 no valid mid close", cfgValid, 0);
    sendWord(16'hFA5A);
    check("R10 valid after gaps", cfgValid, 1);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fullFrame();
    t_trigTable();
    t_skip();
    t_idleJunk();
    t_badClose();
    t_gaps();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule